// File: doc/BRIEF.md
# Programming-Status Read Responder

This block is the read path of a byte-wide nonvolatile memory model. While no programming cycle runs, a read returns the array byte unchanged. While a programming cycle is busy, the returned byte carries two completion indicators. The host can use either one to find out when programming has finished. The first is an inverted copy of bit 7 of the last byte written, returned when the host reads that byte's address. The second is a bit 6 that changes value on every new read access.

The memory is modelled as a clocked design. The active-low strobes, the address and the busy flag are sampled on each rising clock edge. The response appears on the registered outputs one cycle later. No electrical delays are modelled and there are no tri-state drivers. A drive-enable output marks when the data bus would be driven, and the data bus is forced to zero while it is released. The reset input is active low and asynchronous, and it must already be released synchronously to the clock.

Top module: `prog_status_reader`

## Requirements
- R1: `dout_en` is 1 in the cycle after a sample with `ce_n`=0, `oe_n`=0 and `we_n`=1, and is 0 after any other sample. While `dout_en` is 0, `dout` is 0. Both outputs are 0 after reset.
- R2: When the sample shows a read and `busy`=0, `dout` in the next cycle equals `array_rdata` from that sample.
- R3: When the sample shows a read, `busy`=1 and `addr` equals `last_addr`, bit 7 of `dout` in the next cycle is the inverse of bit 7 of `last_data`.
- R4: During a busy period, each new read access returns bit 6 inverted relative to the previous access in the same period.
- R5: The first new read access of each busy period returns bit 6 = 0, whatever value the toggle held when the previous period ended.
- R6: A read that stays selected across cycles, with no new access, keeps bit 6 stable while busy.
- R7: A new access is a change from not-selected to selected, where selected means `ce_n`=0, `oe_n`=0 and `we_n`=1. Cycling `oe_n` alone, `ce_n` alone, or both, each counts as one new access.
- R8: Once `busy` is 0, reads return the true array byte on every bit, and bit 6 no longer changes between accesses.
- R9: During a busy read of an address other than `last_addr`, bit 7 and bits 5..0 come from `array_rdata`, and only bit 6 carries the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a read requires it high |
| addr | input | 15 | Read address |
| busy | input | 1 | Programming cycle in progress |
| last_addr | input | 15 | Address of the most recently written byte |
| last_data | input | 8 | Value of the most recently written byte |
| array_rdata | input | 8 | Array contents at `addr` |
| dout | output | 8 | Read data, zero while released |
| dout_en | output | 1 | Data bus driven |

## Verification
The embedded properties check three things on every clock cycle. The first is the one-cycle link between the read-select condition and the drive enable. The second is that idle reads return the array byte unchanged. The third is that the poll bit is inverted at the last written address, and bit 6 is held steady while a read stays selected. Other behaviours depend on sequences of accesses, so only the bench scenarios show them: bit 6 alternating across accesses made through different strobes, the toggle restarting at 0 in a new busy period, and the toggle stopping once programming ends.

// File: rtl/prog_status_pkg.sv
package prog_status_pkg;
  // How the output register is loaded in a given cycle.
  typedef enum logic [1:0] {
    RD_OFF    = 2'd0,
    RD_TRUE   = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/rd_access_detect.sv
module rd_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic sel,
  output logic sel_q,
  output logic access
);
  logic sel_d;

  // Combined read-select condition.
  always_comb begin
    sel   = ~ce_n & ~oe_n & we_n;
    sel_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  // A new access is the entry into the selected state.
  always_comb access = sel & ~sel_q;
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic access,
  output logic bit_now
);
  logic busy_q, busy_d;
  logic tog_q, tog_d;
  logic shown_q, shown_d;
  logic tog_cur;
  logic take;

  always_comb begin
    // The toggle restarts at 0 when a busy period begins.
    tog_cur = (busy & ~busy_q) ? 1'b0 : tog_q;
    take    = busy & access;
    busy_d  = busy;
    tog_d   = take ? ~tog_cur : tog_cur;
    shown_d = take ? tog_cur : shown_q;
    bit_now = take ? tog_cur : shown_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tog_q   <= 1'b0;
      shown_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      tog_q   <= tog_d;
      if (take) shown_q <= shown_d;
    end
  end

  // After any busy access, the value held for the next access is the opposite of the one just shown.
  assert_toggle_alternates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && access) |=> (tog_q != shown_q));

  // When an access coincides with the start of a busy period, it shows 0.
  assert_toggle_start_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !busy_q && access) |=> (shown_q == 1'b0));
endmodule

// File: rtl/status_mux.sv
module status_mux #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic              tog_bit,
  output logic [DATA_W-1:0] status_byte
);
  logic hit;
  always_comb hit = (addr == last_addr);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == TOG_BIT) begin : g_tog
      assign status_byte[i] = tog_bit;
    end else if (i == POLL_BIT) begin : g_poll
      assign status_byte[i] = hit ? ~last_data[i] : array_rdata[i];
    end else begin : g_pass
      assign status_byte[i] = array_rdata[i];
    end
  end
endmodule

// File: rtl/prog_status_reader.sv
module prog_status_reader
  import prog_status_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              sel, sel_q, access, tog_bit;
  logic [DATA_W-1:0] status_byte, dout_d;
  logic              en_d;
  rd_mode_e          mode;

  rd_access_detect u_detect (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .sel(sel), .sel_q(sel_q), .access(access)
  );

  poll_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .busy(busy), .access(access), .bit_now(tog_bit)
  );

  status_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)
  ) u_mux (
    .addr(addr), .last_addr(last_addr), .last_data(last_data),
    .array_rdata(array_rdata), .tog_bit(tog_bit), .status_byte(status_byte)
  );

  always_comb begin
    if (!sel)     mode = RD_OFF;
    else if (busy) mode = RD_STATUS;
    else          mode = RD_TRUE;
    en_d = (mode != RD_OFF);
    case (mode)
      RD_TRUE:   dout_d = array_rdata;
      RD_STATUS: dout_d = status_byte;
      default:   dout_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout    <= dout_d;
      dout_en <= en_d;
    end
  end

  assert_drive_follows_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n) |=> dout_en);
  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_n && !oe_n && we_n) |=> (!dout_en && dout == '0));
  assert_idle_true_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && !busy) |=> (dout == $past(array_rdata)));
  assert_poll_inverted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && busy && addr == last_addr)
      |=> (dout[POLL_BIT] == ~$past(last_data[POLL_BIT])));
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && sel_q && busy && $past(busy)) |=> (dout[TOG_BIT] == $past(dout[TOG_BIT])));
endmodule

// File: tb/prog_status_reader_tb.sv
module prog_status_reader_tb;
  logic        clk, rst_n, ce_n, oe_n, we_n, busy;
  logic [14:0] addr, last_addr;
  logic [7:0]  last_data, array_rdata, dout;
  logic        dout_en;
  int checks = 0, failures = 0, cycles = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  prog_status_reader u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .busy(busy), .last_addr(last_addr), .last_data(last_data),
    .array_rdata(array_rdata), .dout(dout), .dout_en(dout_en)
  );

  // Array content model: byte value derived from the address.
  assign array_rdata = addr[7:0] ^ 8'h5A;

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic step(input logic c, input logic o, input logic w, input logic [14:0] a,
                      input logic b, input logic e, input logic [7:0] d, input string tag);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = a; busy = b;
    exp_q.push_back({e, d});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares one queued expectation per cycle, away from the edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [8:0] ex;
      string t;
      ex = exp_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if ({dout_en, dout} !== ex) begin
        failures++;
        $display("FAIL %s: actual en=%0b d=%02h expected en=%0b d=%02h",
                 t, dout_en, dout, ex[8], ex[7:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; busy = 0;
    addr = '0; last_addr = 15'h1234; last_data = 8'hC3;
    repeat (3) @(negedge clk);
    checks++;
    if (dout_en !== 1'b0 || dout !== 8'h00) begin
      failures++;
      $display("FAIL R1 reset: actual en=%0b d=%02h expected en=0 d=00", dout_en, dout);
    end
    rst_n = 1;
    // R1: not selected, write strobe, output disabled
    step(1, 0, 1, 15'h0010, 0, 0, 8'h00, "R1 ce high");
    step(0, 0, 0, 15'h0010, 0, 0, 8'h00, "R1 we low");
    step(0, 1, 1, 15'h0010, 0, 0, 8'h00, "R1 oe high");
    // R2: idle true data, 0x10^0x5A = 0x4A
    step(0, 0, 1, 15'h0010, 0, 1, 8'h4A, "R2 idle read");
    step(0, 0, 1, 15'h0010, 0, 1, 8'h4A, "R2 idle hold");
    // busy period 1 begins; mem(1234)=0x6E
    step(1, 1, 1, 15'h1234, 1, 0, 8'h00, "R1 busy released");
    step(0, 0, 1, 15'h1234, 1, 1, 8'h2E, "R3 R5 first poll");
    step(0, 0, 1, 15'h1234, 1, 1, 8'h2E, "R6 held read");
    step(0, 1, 1, 15'h1234, 1, 0, 8'h00, "R7 oe up");
    step(0, 0, 1, 15'h1234, 1, 1, 8'h6E, "R4 R7 oe access");
    step(1, 0, 1, 15'h1234, 1, 0, 8'h00, "R7 ce up");
    step(0, 0, 1, 15'h1234, 1, 1, 8'h2E, "R4 R7 ce access");
    step(1, 1, 1, 15'h1234, 1, 0, 8'h00, "R7 both up");
    step(0, 0, 1, 15'h1234, 1, 1, 8'h6E, "R4 R7 both access");
    step(1, 1, 1, 15'h0010, 1, 0, 8'h00, "R1 release");
    step(0, 0, 1, 15'h0010, 1, 1, 8'h0A, "R9 other address");
    // programming ends while selected
    step(0, 0, 1, 15'h0010, 0, 1, 8'h4A, "R8 busy falls");
    step(1, 1, 1, 15'h0010, 0, 0, 8'h00, "R1 release idle");
    step(0, 0, 1, 15'h0010, 0, 1, 8'h4A, "R8 no toggle a");
    step(1, 1, 1, 15'h0010, 0, 0, 8'h00, "R1 release idle 2");
    step(0, 0, 1, 15'h0010, 0, 1, 8'h4A, "R8 no toggle b");
    // busy period 2, last byte bit7=0 so poll bit reads 1
    last_data = 8'h05;
    step(1, 1, 1, 15'h1234, 1, 0, 8'h00, "R1 busy2 released");
    step(0, 0, 1, 15'h1234, 1, 1, 8'hAE, "R5 R3 restart at 0");
    step(1, 1, 1, 15'h1234, 1, 0, 8'h00, "R1 release busy2");
    step(0, 0, 1, 15'h1234, 1, 1, 8'hEE, "R4 second access");
    step(1, 1, 1, 15'h1234, 0, 0, 8'h00, "R1 end");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule